// File: doc/BRIEF.md
# Push-Button Conditioning and Press Counter

This block takes the raw level of a mechanical push-button. That level is asynchronous to the clock, it bounces when the contact closes or opens, and it can carry short noise spikes. The block turns it into exactly one count per real press. The counted value is meant to drive a row of LEDs in binary.

The signal moves through a fixed chain of stages:
- a two-register synchronizer;
- a debounce register that samples only on a slow periodic tick;
- a three-sample majority vote over those slow samples;
- a rising-edge detector;
- a wrapping binary counter.

The tick divisor is a parameter. At its default it gives a 100 Hz sample rate from a 100 MHz clock, which suits contact bounce that lasts less than 10 ms. A bench can set it much lower. Every intermediate stage output is also brought to a port, so that each stage can be observed.

Top module: `button_pulse_counter`

## Requirements
- R1: `sync_out` equals the value `btn_raw` had two clock edges earlier. No stage reads `btn_raw` directly.
- R2: An internal sample tick is asserted for one cycle once every `TICK_DIV` cycles.
- R3: `deb_out` changes only on a tick, where it takes the value of `sync_out`. As a result, any two changes of `deb_out` are a whole multiple of `TICK_DIV` cycles apart.
- R4: A bounce burst shorter than `TICK_DIV` cycles, followed by a stable level, gives exactly one count increment per press.
- R5: `vote_out` is 1 when at least two of the last three debounced samples are 1, and 0 otherwise. An isolated high spike shorter than `TICK_DIV` cycles never raises `vote_out` and never changes `count`. After `btn_raw` goes high, `vote_out` stays 0 for at least 2*`TICK_DIV`+2 cycles.
- R6: A low glitch shorter than `TICK_DIV` cycles while the button is held does not produce an extra count. A release is recognised only after it lasts across the voting window.
- R7: `pulse_out` is high for exactly one cycle on each rising edge of `vote_out`.
- R8: `count` increases by one on the clock edge that follows a cycle with `pulse_out` high. It holds its value otherwise, and it wraps from 2^`CNT_W`-1 to 0.
- R9: While `rst` (active high, synchronous) is asserted, all outputs are driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Unsynchronized button level |
| count | output | CNT_W | Press counter value for the LEDs |
| sync_out | output | 1 | Synchronizer output (test) |
| deb_out | output | 1 | Debounced sample (test) |
| vote_out | output | 1 | Majority-filtered level (test) |
| pulse_out | output | 1 | One-cycle rising-edge pulse (test) |

## Verification
A tick generator with the wrong period shows up on `deb_out`: its changes stop falling on whole multiples of `TICK_DIV` cycles, and this is visible at the first pair of transitions. A corrupted vote register or edge register shows up at `count` within a single press or spike. It appears as a missing count, a double count, or a count caused by a spike, and the scoreboard catches it when it compares the next count change. A wrong synchronizer depth is seen two cycles after a single input step.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int VOTE_LEN = 3;

  function automatic logic vote_major(input logic [VOTE_LEN-1:0] v);
    return $countones(v) > (VOTE_LEN / 2);
  endfunction
endpackage

// File: rtl/bpc_sync.sv
module bpc_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [DEPTH-1:0] stage;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= 1'b0;
          else     stage[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= 1'b0;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q_out = stage[DEPTH-1];
endmodule

// File: rtl/bpc_tick.sv
module bpc_tick #(
  parameter int TICK_DIV = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/bpc_filter.sv
module bpc_filter
  import bpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic level_in,
  output logic deb_q,
  output logic vote_q
);
  logic [VOTE_LEN-1:0] hist;

  // debounce register: one sample per tick
  always_ff @(posedge clk) begin
    if (rst)       deb_q <= 1'b0;
    else if (tick) deb_q <= level_in;
  end

  // history of slow samples
  always_ff @(posedge clk) begin
    if (rst)       hist <= '0;
    else if (tick) hist <= {hist[VOTE_LEN-2:0], deb_q};
  end

  assign vote_q = vote_major(hist);
endmodule

// File: rtl/bpc_edge.sv
module bpc_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= level_in;
  end

  assign rise = level_in & ~prev;
endmodule

// File: rtl/button_pulse_counter.sv
module button_pulse_counter #(
  parameter int TICK_DIV   = 1_000_000,
  parameter int CNT_W      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_raw,
  output logic [CNT_W-1:0] count,
  output logic             sync_out,
  output logic             deb_out,
  output logic             vote_out,
  output logic             pulse_out
);
  logic tick;

  bpc_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (btn_raw),
    .q_out (sync_out)
  );

  bpc_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  bpc_filter u_filter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .level_in (sync_out),
    .deb_q    (deb_out),
    .vote_q   (vote_out)
  );

  bpc_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (vote_out),
    .rise     (pulse_out)
  );

  always_ff @(posedge clk) begin
    if (rst)            count <= '0;
    else if (pulse_out) count <= count + 1'b1;
  end
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int TICK_DIV = 1_000_000,
  parameter int CNT_W    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             btn_raw,
  input logic [CNT_W-1:0] count,
  input logic             sync_out,
  input logic             deb_out,
  input logic             vote_out,
  input logic             pulse_out,
  input logic             tick
);
  localparam int GW = $clog2(TICK_DIV + 1) + 1;

  logic [1:0]    warm;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       gap <= '0;
    else if (tick) gap <= '0;
    else           gap <= gap + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst) begin
      AST_TICK_PERIOD: assert (!tick || gap == GW'(TICK_DIV - 1)); // R2
    end
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2) |-> (sync_out == $past(btn_raw, 2))); // R1

  AST_DEB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(deb_out)); // R3

  AST_DEB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    tick |=> (deb_out == $past(sync_out))); // R3

  AST_VOTE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(vote_out)); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_out |=> !pulse_out); // R7

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd1) |-> (pulse_out == (vote_out && !$past(vote_out)))); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    pulse_out |=> (count == $past(count) + 1'b1)); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pulse_out |=> $stable(count)); // R8
endmodule

bind button_pulse_counter bpc_checker #(
  .TICK_DIV (TICK_DIV),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .btn_raw   (btn_raw),
  .count     (count),
  .sync_out  (sync_out),
  .deb_out   (deb_out),
  .vote_out  (vote_out),
  .pulse_out (pulse_out),
  .tick      (tick)
);

// File: tb/button_pulse_counter_test.sv
module button_pulse_counter_test;
  localparam int DIV = 8;
  localparam int CW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          btn_raw = 1'b0;
  logic [CW-1:0] count;
  logic          sync_out, deb_out, vote_out, pulse_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int exp_count = 0;
  int exp_q[$];
  bit done = 1'b0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  button_pulse_counter #(.TICK_DIV(DIV), .CNT_W(CW)) uut (
    .clk       (clk),
    .rst       (rst),
    .btn_raw   (btn_raw),
    .count     (count),
    .sync_out  (sync_out),
    .deb_out   (deb_out),
    .vote_out  (vote_out),
    .pulse_out (pulse_out)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: a real press, optional bounce on both edges
  task automatic press(input bit bouncy);
    if (bouncy) begin
      btn_raw = 1; wait_cyc(1); btn_raw = 0; wait_cyc(1);
      btn_raw = 1; wait_cyc(2); btn_raw = 0; wait_cyc(1);
    end
    btn_raw = 1;
    exp_count = (exp_count + 1) % (1 << CW);
    exp_q.push_back(exp_count);
    wait_cyc(6 * DIV);
    if (bouncy) begin
      btn_raw = 0; wait_cyc(1); btn_raw = 1; wait_cyc(2);
      btn_raw = 0; wait_cyc(1); btn_raw = 1; wait_cyc(1);
    end
    btn_raw = 0;
    wait_cyc(6 * DIV);
  endtask

  // monitor: scoreboard on count, R7 pulse relation, R3 spacing
  int last_count = 0;
  bit last_pulse = 1'b0;
  bit last_deb   = 1'b0;
  int last_deb_cyc = -1;
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (int'(count) != last_count) begin
        check("R7 pulse before count step", int'(last_pulse), 1);
        if (exp_q.size() == 0) check("R8 unexpected count change", int'(count), last_count);
        else check("R8 count scoreboard", int'(count), exp_q.pop_front());
      end
      if (pulse_out && last_pulse) check("R7 pulse width", 2, 1);
      if (deb_out != last_deb) begin
        if (last_deb_cyc >= 0) check("R3 deb spacing mod DIV", (cyc - last_deb_cyc) % DIV, 0);
        last_deb_cyc = cyc;
      end
    end
    last_count = int'(count);
    last_pulse = pulse_out;
    last_deb   = deb_out;
  end

  initial begin
    wait_cyc(3);
    check("R9 count in reset", int'(count), 0);
    check("R9 sync in reset", int'(sync_out), 0);
    check("R9 deb in reset", int'(deb_out), 0);
    check("R9 vote in reset", int'(vote_out), 0);
    check("R9 pulse in reset", int'(pulse_out), 0);
    rst = 0;
    wait_cyc(2 * DIV);
    mon_on = 1'b1;

    // R1: two-edge synchronizer latency
    btn_raw = 1;
    wait_cyc(1);
    check("R1 sync after one edge", int'(sync_out), 0);
    wait_cyc(1);
    check("R1 sync after two edges", int'(sync_out), 1);
    btn_raw = 0;
    wait_cyc(8 * DIV);
    check("R5 short press stays low", int'(count), 0);

    // R5: vote timing on a clean press
    btn_raw = 1;
    exp_count = (exp_count + 1) % (1 << CW);
    exp_q.push_back(exp_count);
    wait_cyc(2 * DIV + 2);
    check("R5 vote not yet high", int'(vote_out), 0);
    wait_cyc(2 * DIV + 2);
    check("R5 vote high after window", int'(vote_out), 1);
    wait_cyc(2 * DIV);
    btn_raw = 0;
    wait_cyc(6 * DIV);
    check("R5 vote released", int'(vote_out), 0);

    // R5: isolated high spikes are ignored
    for (int k = 0; k < 4; k++) begin
      btn_raw = 1; wait_cyc(DIV - 2 - k);
      btn_raw = 0; wait_cyc(4 * DIV + k);
    end
    check("R5 spikes no count", int'(count), exp_count);

    // R4: bouncing presses count once each
    press(1'b1);
    press(1'b1);
    check("R4 bouncy presses", int'(count), exp_count);

    // R6: low glitch while held
    btn_raw = 1;
    exp_count = (exp_count + 1) % (1 << CW);
    exp_q.push_back(exp_count);
    wait_cyc(6 * DIV);
    btn_raw = 0; wait_cyc(DIV - 2);
    btn_raw = 1; wait_cyc(4 * DIV);
    check("R6 glitch vote held", int'(vote_out), 1);
    btn_raw = 0; wait_cyc(6 * DIV);
    check("R6 glitch single count", int'(count), exp_count);

    // R8: wrap-around
    for (int k = 0; k < 6; k++) press(1'b0);
    check("R8 wrapped value", int'(count), exp_count);
    check("R8 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule